// File: doc/BRIEF.md
# Four-Tap Filter Datapath with Row-Addressed Coefficient Banks

The block multiplies four 12-bit two's complement samples by four 12-bit two's complement coefficients and adds the four products into a 32-bit signed sum. Each sample lane has its own register with an active-low hold control. The coefficients come from four banks of 256 rows, one bank per multiplier. A registered row address picks the row that all four banks present. On the clock edge after the row register loads, the coefficients of that row enter the coefficient registers in front of the multipliers.

A 5-bit window code takes a 16-bit slice of the registered sum and places it in the output register. Code n selects sum bits 15+n down to n. Code 0 gives an integer reading of the low half. Code 16 gives the upper half, which suits a fractional reading. The output port goes to high impedance while the active-low output enable is high.

Coefficients arrive on a separate 12-bit load bus that has its own strobe clock. Words on that bus come in pairs. The first word of a pair is an address word that names the bank and the row. The second word is the coefficient that gets written there.

Top module: `quad_tap_filter`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the output register holds 0. The sample, row and coefficient registers also clear to 0.
- R2: Sample lane i captures `smp_i[i]` on a rising `clk` edge only while `smp_en_n[i]` is low. While that enable is high, the lane keeps its old value.
- R3: The row register captures `row_i` on a rising `clk` edge only while `row_en_n` is low. While `row_en_n` is high, the row register holds.
- R4: While `ld_n` is low, the words written on rising `ld_clk` edges alternate between two kinds. The first is an address word: bits 9:8 give the bank and bits 7:0 give the row. The second is a data word: the 12-bit coefficient written to that bank and row. While `ld_n` is high, the next word is taken as an address word again.
- R5: The output equals the windowed 32-bit signed sum of the four products of sample and coefficient, each 24-bit product sign-extended. A sample change reaches the output on the third rising `clk` edge after it is applied, and not before.
- R6: A row address change reaches the output on the fourth rising `clk` edge after it is applied. The stages are the row register, the coefficient registers, the sum register and the output register.
- R7: Window code n, for n from 0 to 16, loads sum bits [15+n:n] into output bits [15:0].
- R8: Window codes 17 to 31 behave exactly as code 16.
- R9: While `oe_n` is high, `res_o` is high impedance. While `oe_n` is low, `res_o` drives the output register.
- R10: Words on `ld_bus` while `ld_n` is high write no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 4x12 | Sample inputs, lane i in `smp_i[i]` |
| smp_en_n | input | 4 | Active-low capture enable, one per lane |
| row_i | input | 8 | Coefficient row address |
| row_en_n | input | 1 | Active-low row register enable |
| ld_clk | input | 1 | Coefficient load strobe |
| ld_n | input | 1 | Active-low load qualifier |
| ld_bus | input | 12 | Address or coefficient word |
| shift_i | input | 5 | Output window code |
| oe_n | input | 1 | Active-low output enable |
| res_o | output | 16 | Windowed result, high impedance when disabled |

## Verification
The bench goes after the edges of the window. With codes 0, 16 and 17 to 31 and full-scale negative operands, a design with an off-by-one slice shows wrong sign bits, and one that wraps codes above 16 shows low-order bits. It counts edges separately for a sample change and a row change: a design that is one register short or one register long shows the old or new value at the wrong check. It also checks held lanes, held rows, load bus activity with `ld_n` high, and the disabled output. A design that ignored any of these controls would show a changed result at the port.

// File: rtl/qtf_pkg.sv
package qtf_pkg;
    localparam int NTAP   = 4;
    localparam int SMP_W  = 12;
    localparam int COEF_W = 12;
    localparam int ROW_W  = 8;
    localparam int BANK_W = $clog2(NTAP);
    localparam int PROD_W = SMP_W + COEF_W;
    localparam int SUM_W  = 32;
    localparam int OUT_W  = 16;
    localparam int SH_W   = 5;
    localparam int SH_MAX = SUM_W - OUT_W;
    localparam int DEPTH  = 1 << ROW_W;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    typedef struct packed {
        logic              we;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        coef_t             data;
    } ld_cmd_t;

    function automatic sum_t widen(input logic signed [PROD_W-1:0] p);
        return sum_t'(p);
    endfunction

    function automatic logic [OUT_W-1:0] window(input sum_t s, input logic [SH_W-1:0] n);
        logic [SH_W-1:0] eff;
        logic [SUM_W-1:0] sh;
        eff = (int'(n) > SH_MAX) ? SH_W'(SH_MAX) : n;
        sh  = s >> eff;
        return sh[OUT_W-1:0];
    endfunction
endpackage

// File: rtl/qtf_loader.sv
module qtf_loader
    import qtf_pkg::*;
(
    input  logic              ld_clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic [COEF_W-1:0] ld_bus,
    output ld_cmd_t           cmd
);
    logic              phase_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;

    always_ff @(posedge ld_clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            bank_q  <= '0;
            row_q   <= '0;
        end else if (ld_n) begin
            phase_q <= 1'b0;
        end else if (!phase_q) begin
            bank_q  <= ld_bus[ROW_W+BANK_W-1:ROW_W];
            row_q   <= ld_bus[ROW_W-1:0];
            phase_q <= 1'b1;
        end else begin
            phase_q <= 1'b0;
        end
    end

    always_comb begin
        cmd.we   = !ld_n && phase_q;
        cmd.bank = bank_q;
        cmd.row  = row_q;
        cmd.data = coef_t'(ld_bus);
    end

    // R4
    ctl_phase_chk: assert property (@(posedge ld_clk) disable iff (rst)
        ld_n |=> !phase_q);

    // R10
    no_write_chk: assert property (@(posedge ld_clk) disable iff (rst)
        ld_n |-> !cmd.we);
endmodule

// File: rtl/qtf_coef_bank.sv
module qtf_coef_bank
    import qtf_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic             clk,
    input  logic             ld_clk,
    input  logic             rst,
    input  ld_cmd_t          cmd,
    input  logic [ROW_W-1:0] rd_row,
    output coef_t            k_q
);
    coef_t mem [DEPTH];

    always_ff @(posedge ld_clk) begin
        if (cmd.we && (int'(cmd.bank) == BANK_ID))
            mem[cmd.row] <= cmd.data;
    end

    always_ff @(posedge clk) begin
        if (rst) k_q <= '0;
        else     k_q <= mem[rd_row];
    end
endmodule

// File: rtl/qtf_sum_tree.sv
module qtf_sum_tree
    import qtf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  smp_t  smp [NTAP],
    input  coef_t k   [NTAP],
    output sum_t  sum_q
);
    logic signed [PROD_W-1:0] prod [NTAP];
    sum_t acc;

    for (genvar i = 0; i < NTAP; i++) begin : g_mul
        assign prod[i] = smp[i] * k[i];
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAP; i++) acc = acc + widen(prod[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) sum_q <= '0;
        else     sum_q <= acc;
    end
endmodule

// File: rtl/qtf_out_stage.sv
module qtf_out_stage
    import qtf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  sum_t            sum_q,
    input  logic [SH_W-1:0] shift_i,
    input  logic            oe_n,
    output logic [OUT_W-1:0] res_o
);
    logic [OUT_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= window(sum_q, shift_i);
    end

    assign res_o = oe_n ? {OUT_W{1'bz}} : out_q;

    // R8
    sat_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(shift_i) > SH_MAX) |=> out_q == $past(sum_q[SUM_W-1:SUM_W-OUT_W]));

    // R7
    low_win_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_i == '0) |=> out_q == $past(sum_q[OUT_W-1:0]));
endmodule

// File: rtl/quad_tap_filter.sv
module quad_tap_filter
    import qtf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NTAP-1:0][SMP_W-1:0] smp_i,
    input  logic [NTAP-1:0]            smp_en_n,
    input  logic [ROW_W-1:0]           row_i,
    input  logic                       row_en_n,
    input  logic                       ld_clk,
    input  logic                       ld_n,
    input  logic [COEF_W-1:0]          ld_bus,
    input  logic [SH_W-1:0]            shift_i,
    input  logic                       oe_n,
    output logic [OUT_W-1:0]           res_o
);
    smp_t             d_q [NTAP];
    coef_t            k_q [NTAP];
    logic [ROW_W-1:0] row_q;
    ld_cmd_t          cmd;
    sum_t             sum_q;

    for (genvar i = 0; i < NTAP; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)              d_q[i] <= '0;
            else if (!smp_en_n[i]) d_q[i] <= smp_t'(smp_i[i]);
        end

        // R2
        smp_hold_chk: assert property (@(posedge clk) disable iff (rst)
            smp_en_n[i] |=> d_q[i] == $past(d_q[i]));

        qtf_coef_bank #(.BANK_ID(i)) u_bank (
            .clk    (clk),
            .ld_clk (ld_clk),
            .rst    (rst),
            .cmd    (cmd),
            .rd_row (row_q),
            .k_q    (k_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)            row_q <= '0;
        else if (!row_en_n) row_q <= row_i;
    end

    // R3
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        row_en_n |=> row_q == $past(row_q));

    qtf_loader u_loader (
        .ld_clk (ld_clk),
        .rst    (rst),
        .ld_n   (ld_n),
        .ld_bus (ld_bus),
        .cmd    (cmd)
    );

    qtf_sum_tree u_sum (
        .clk   (clk),
        .rst   (rst),
        .smp   (d_q),
        .k     (k_q),
        .sum_q (sum_q)
    );

    qtf_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .sum_q   (sum_q),
        .shift_i (shift_i),
        .oe_n    (oe_n),
        .res_o   (res_o)
    );
endmodule

// File: tb/quad_tap_filter_tb.sv
module quad_tap_filter_tb;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic [3:0][11:0] smp_i;
    logic [3:0]       smp_en_n;
    logic [7:0]       row_i;
    logic             row_en_n;
    logic             ld_n;
    logic [11:0]      ld_bus;
    logic [4:0]       shift_i;
    logic             oe_n;
    logic [15:0]      res_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [11:0] coef_m [4][256];
    logic [11:0] smp_m  [4];
    logic [7:0]  row_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_tap_filter u_dut (
        .clk(clk), .rst(rst), .smp_i(smp_i), .smp_en_n(smp_en_n),
        .row_i(row_i), .row_en_n(row_en_n), .ld_clk(clk), .ld_n(ld_n),
        .ld_bus(ld_bus), .shift_i(shift_i), .oe_n(oe_n), .res_o(res_o)
    );

    function automatic logic signed [31:0] model_sum();
        logic signed [31:0] s = 0;
        for (int i = 0; i < 4; i++)
            s += 32'(signed'(smp_m[i])) * 32'(signed'(coef_m[i][row_m]));
        return s;
    endfunction

    function automatic logic [15:0] model_out(input logic [4:0] n);
        int e = (n > 16) ? 16 : int'(n);
        logic [31:0] s = model_sum();
        return 16'(s >> e);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int b, input int r, input logic [11:0] v);
        ld_n = 1'b0;
        ld_bus = {2'b00, 2'(b), 8'(r)};
        step(1);
        ld_bus = v;
        step(1);
        ld_n = 1'b1;
        ld_bus = $urandom;
        step(1);
        coef_m[b][r] = v;
    endtask

    task automatic apply(input logic [3:0][11:0] s, input logic [7:0] r);
        smp_i = s;
        row_i = r;
        for (int i = 0; i < 4; i++) smp_m[i] = s[i];
        row_m = r;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; smp_i = '0; smp_en_n = '0; row_i = '0; row_en_n = 1'b0;
        ld_n = 1'b1; ld_bus = '0; shift_i = '0; oe_n = 1'b0;
        step(3);
        chk("R1 reset", res_o, 16'h0000);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) smp_m[i] = '0;
        row_m = '0;
        step(1);
        chk("R1 after reset", res_o, 16'h0000);

        // R4 / R10: fill rows 0..15 of every bank, plus extremes
        for (int r = 0; r < 16; r++)
            for (int b = 0; b < 4; b++) load(b, r, 12'($urandom));
        for (int b = 0; b < 4; b++) load(b, 255, 12'h800);
        for (int b = 0; b < 4; b++) load(b, 254, 12'h7FF);

        // R5 / R7 full-scale negative: 4 * (-2048)^2 = 0x0100_0000
        apply({4{12'h800}}, 8'd255);
        shift_i = 5'd16; step(5);
        chk("R7 code16 extreme", res_o, model_out(5'd16));
        shift_i = 5'd0; step(2);
        chk("R7 code0 extreme", res_o, 16'h0000);
        shift_i = 5'd9; step(2);
        chk("R7 code9 extreme", res_o, 16'h8000);
        apply({4{12'h800}}, 8'd254);
        shift_i = 5'd16; step(5);
        chk("R7 mixed sign", res_o, model_out(5'd16));

        // R8: codes above 16 equal code 16
        apply({12'h123, 12'h9AB, 12'h7FF, 12'h801}, 8'd3);
        for (int c = 17; c < 32; c += 7) begin
            shift_i = 5'(c); step(5);
            chk("R8 saturated code", res_o, model_out(5'd16));
        end

        // R5: sample latency three edges
        apply({12'h000, 12'h000, 12'h000, 12'h000}, 8'd255);
        shift_i = 5'd0; step(5);
        smp_i[0] = 12'h001; smp_m[0] = 12'h001;
        step(2);
        chk("R5 not before third edge", res_o, 16'h0000);
        step(1);
        chk("R5 at third edge", res_o, 16'hF800);

        // R6: row latency four edges
        apply({12'h000, 12'h000, 12'h000, 12'h001}, 8'd254);
        step(5);
        chk("R6 settle", res_o, 16'h07FF);
        row_i = 8'd255; row_m = 8'd255;
        step(3);
        chk("R6 not before fourth edge", res_o, 16'h07FF);
        step(1);
        chk("R6 at fourth edge", res_o, 16'hF800);

        // R2: held lane keeps old sample
        smp_en_n = 4'b0010;
        smp_i[1] = 12'h7FF;
        step(5);
        chk("R2 lane hold", res_o, model_out(5'd0));
        smp_en_n = '0;
        smp_m[1] = 12'h7FF;
        step(5);
        chk("R2 lane release", res_o, model_out(5'd0));

        // R3: held row register
        row_en_n = 1'b1;
        row_i = 8'd2;
        step(5);
        chk("R3 row hold", res_o, model_out(5'd0));
        row_en_n = 1'b0;
        row_m = 8'd2;
        step(5);
        chk("R3 row release", res_o, model_out(5'd0));

        // R10: bus activity with ld_n high writes nothing
        for (int i = 0; i < 6; i++) begin
            ld_bus = (i % 2 == 0) ? 12'h002 : 12'h555;
            step(1);
        end
        step(4);
        chk("R10 no write", res_o, model_out(5'd0));

        // R4: a data word alone after ld_n high is taken as address
        load(1, 2, 12'h3C1);
        step(5);
        chk("R4 write visible", res_o, model_out(5'd0));

        // R9: disabled output does not drive the value
        apply({12'h001, 12'h000, 12'h000, 12'h000}, 8'd254);
        step(5);
        chk("R9 enabled", res_o, 16'h07FF);
        oe_n = 1'b1; step(1);
        n_chk++;
        if (res_o === 16'h07FF) begin
            n_bad++;
            $display("FAIL R9 tristate: got %h expected not 07ff", res_o);
        end
        oe_n = 1'b0;

        // R5 / R7: random vectors
        for (int v = 0; v < 300; v++) begin
            logic [3:0][11:0] s;
            logic [4:0] c;
            for (int i = 0; i < 4; i++) s[i] = 12'($urandom);
            c = 5'($urandom_range(0, 31));
            apply(s, 8'($urandom_range(0, 15)));
            shift_i = c;
            step(5);
            chk("R5 R7 random", res_o, model_out(c));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule